// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block counts activity on one input pin. In event mode every transition of a chosen polarity adds one to the count. In gated mode the count advances once for every 64 clock cycles that the pin spends at its enabled level, which measures how long the pin stays in that state. The count is built from 8-bit lanes. A lane works alone as an 8-bit counter, or lanes chain their carries into one wider counter, 16 bits with the default two lanes.

Software sets the block up through a small write-only register port. That port holds the control byte, a write-one-to-clear flag register and direct preset of each count byte. The block keeps two sticky flags: one for a detected pin transition and one for a count wrap. Each flag has its own interrupt enable. A saturate option makes the counter stop at its all-ones value instead of wrapping. A latch strobe from outside the block copies the current count into a holding register, so a count taken at a chosen instant can be read later without racing the live counter.

Top module: `pacc_top`

## Requirements
- R1: After reset, count, hold, both flags and both interrupts are 0. The control byte is 0, so the block is disabled, in event mode and uses polarity 0.
- R2: With enable set and gated mode clear, the count rises by one on every falling pin transition when polarity is 0, and on every rising transition when polarity is 1. The other direction has no effect.
- R3: With enable and gated mode set, the count rises by one at each prescaler tick while the pin is high (polarity 0) or low (polarity 1). It holds while the pin is at the other level. The prescaler runs freely from reset release and ticks once every 64 clock cycles, so any 128 consecutive cycles hold exactly two ticks.
- R4: While enabled, in either mode, the input flag sets on a falling pin transition when polarity is 0 and on a rising one when polarity is 1.
- R5: With cascade clear, the low byte wraps from FF to 00 and the overflow flag sets. The high byte does not change.
- R6: With cascade set, a carry out of the low byte increments the high byte. The overflow flag sets only on the wrap from FFFF to 0000.
- R7: With saturate set, the count stops at FF (8-bit) or FFFF (cascaded) and the overflow flag does not set.
- R8: Writing 1 to a bit of the flag-clear register clears that flag. A flag that is set and cleared in the same cycle stays set.
- R9: The input interrupt equals the input flag AND its enable bit. The overflow interrupt equals the overflow flag AND its enable bit.
- R10: A latch strobe copies into hold the count visible in the cycle of the strobe. Hold does not change otherwise.
- R11: With enable clear, no pin activity changes the count or sets a flag. Count presets still take effect.
- R12: Register port: address 0 is control, address 1 is flag clear (bit 0 input flag, bit 1 overflow flag), address 2 is the low count byte and address 3 is the high count byte. Control bits: 0 enable, 1 gated mode, 2 polarity, 3 cascade, 4 saturate, 5 input interrupt enable, 6 overflow interrupt enable. A count preset in a cycle suppresses that cycle's increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the gated time base is derived from it |
| rst | input | 1 | Synchronous active-high reset |
| pin | input | 1 | Counted input, already synchronous to clk |
| latch_stb | input | 1 | Copies the count into the holding register |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| count | output | 16 | Live count, high byte over low byte |
| hold | output | 16 | Holding register |
| in_flag | output | 1 | Sticky pin-transition flag |
| ovf_flag | output | 1 | Sticky wrap flag |
| in_irq | output | 1 | Input interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The hardest case to reach from the ports is the exact phase of the free-running prescaler in gated mode, because the prescaler can be neither seen nor reset from outside. The bench handles this in two ways. First, a reference model counts cycles from reset release and predicts every tick cycle by cycle. Second, the directed gated checks measure count growth over windows of 128 cycles, which hold exactly two ticks whatever the phase. Collisions are forced on purpose: a flag clear in the same cycle as a wrap, a latch strobe in the same cycle as a counted edge, and presets near FF and FFFF with saturate on and off. Random register traffic then mixes modes while the counter is running.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

    localparam int unsigned LANE_W     = 8;
    localparam int unsigned LANES      = 2;
    localparam int unsigned PRESCALE   = 64;
    localparam int unsigned CTRL_W     = 7;
    localparam int unsigned CNT_BASE   = 2;

    typedef struct packed {
        logic ovf_ie;
        logic in_ie;
        logic sat;
        logic cascade;
        logic pol;
        logic gated;
        logic en;
    } pacc_ctrl_t;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_CLEAR = 2'd1
    } pacc_reg_t;

    typedef struct packed {
        logic ovf;
        logic inp;
    } pacc_flags_t;

    // polarity 0 selects the falling transition, 1 the rising one
    function automatic logic edge_match(logic prev, logic cur, logic pol);
        return pol ? (!prev && cur) : (prev && !cur);
    endfunction

    // polarity 0 counts while high, 1 counts while low
    function automatic logic level_open(logic cur, logic pol);
        return cur ^ pol;
    endfunction

endpackage

// File: rtl/pacc_prescaler.sv
module pacc_prescaler #(
    parameter int unsigned DIV = 64
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (DIV > 1) begin : g_div
            localparam int unsigned PW = $clog2(DIV);
            logic [PW-1:0] phase_q;

            always_ff @(posedge clk) begin
                if (rst)       phase_q <= '0;
                else if (tick) phase_q <= '0;
                else           phase_q <= phase_q + 1'b1;
            end

            assign tick = (phase_q == PW'(DIV - 1));

            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick); // R3
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/pacc_qualifier.sv
module pacc_qualifier
    import pacc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic en,
    input  logic gated,
    input  logic pol,
    input  logic tick,
    output logic inc,
    output logic in_evt
);
    logic pin_q;
    logic hit;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b0;
        else     pin_q <= pin;
    end

    always_comb begin
        hit    = edge_match(pin_q, pin, pol);
        in_evt = en && hit;
        if (gated) inc = en && tick && level_open(pin, pol);
        else       inc = en && hit;
    end
endmodule

// File: rtl/pacc_count.sv
module pacc_count #(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned LANES  = 2,
    localparam int unsigned CNT_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic              cascade,
    input  logic              sat,
    input  logic [LANES-1:0]  lane_wr,
    input  logic [LANE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              wrap
);
    logic [LANES-1:0][LANE_W-1:0] lane_q;
    logic [LANES-1:0]             all_ones;
    logic [LANES-1:0]             carry;
    logic                         any_wr;
    logic                         limit;
    logic                         step;

    assign any_wr = |lane_wr;
    assign limit  = cascade ? (&all_ones) : all_ones[0];
    assign step   = inc && !any_wr && !(sat && limit);
    assign wrap   = inc && !any_wr && !sat && limit;
    assign count  = lane_q;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign all_ones[i] = &lane_q[i];

            if (i == 0) begin : g_first
                assign carry[i] = step;
            end else begin : g_chain
                assign carry[i] = cascade && carry[i-1] && all_ones[i-1];
            end

            always_ff @(posedge clk) begin
                if (rst)             lane_q[i] <= '0;
                else if (lane_wr[i]) lane_q[i] <= wr_data;
                else if (carry[i])   lane_q[i] <= lane_q[i] + 1'b1;
            end
        end

        if (LANES > 1) begin : g_upper_chk
            AST_UPPER_STILL: assert property (@(posedge clk) disable iff (rst)
                (!cascade && !any_wr) |=> $stable(lane_q[LANES-1])); // R5
        end
    endgenerate

    AST_SAT_STICKS: assert property (@(posedge clk) disable iff (rst)
        (inc && sat && limit && !any_wr) |=> (lane_q == $past(lane_q))); // R7

    AST_WRAP_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (lane_q[0] == '0)); // R5
endmodule

// File: rtl/pacc_top.sv
module pacc_top
    import pacc_pkg::*;
#(
    parameter int unsigned LANE_W   = pacc_pkg::LANE_W,
    parameter int unsigned LANES    = pacc_pkg::LANES,
    parameter int unsigned PRESCALE = pacc_pkg::PRESCALE,
    localparam int unsigned CNT_W   = LANE_W * LANES,
    localparam int unsigned ADDR_W  = $clog2(LANES + CNT_BASE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin,
    input  logic              latch_stb,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  hold,
    output logic              in_flag,
    output logic              ovf_flag,
    output logic              in_irq,
    output logic              ovf_irq
);
    pacc_ctrl_t       ctrl_q;
    pacc_flags_t      flags_q;
    pacc_flags_t      clr;
    logic [CNT_W-1:0] hold_q;
    logic [LANES-1:0] lane_wr;
    logic             tick;
    logic             inc;
    logic             in_evt;
    logic             wrap;
    logic             ctrl_wr;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(REG_CTRL));
    assign clr.inp = wr_en && (wr_addr == ADDR_W'(REG_CLEAR)) && wr_data[0];
    assign clr.ovf = wr_en && (wr_addr == ADDR_W'(REG_CLEAR)) && wr_data[1];

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_wsel
            assign lane_wr[i] = wr_en && (wr_addr == ADDR_W'(CNT_BASE + i));
        end
    endgenerate

    pacc_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    pacc_qualifier u_qual (
        .clk    (clk),
        .rst    (rst),
        .pin    (pin),
        .en     (ctrl_q.en),
        .gated  (ctrl_q.gated),
        .pol    (ctrl_q.pol),
        .tick   (tick),
        .inc    (inc),
        .in_evt (in_evt)
    );

    pacc_count #(.LANE_W(LANE_W), .LANES(LANES)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc     (inc),
        .cascade (ctrl_q.cascade),
        .sat     (ctrl_q.sat),
        .lane_wr (lane_wr),
        .wr_data (wr_data),
        .count   (count),
        .wrap    (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            flags_q <= '0;
            hold_q  <= '0;
        end else begin
            if (ctrl_wr)   ctrl_q <= pacc_ctrl_t'(wr_data[CTRL_W-1:0]);
            if (latch_stb) hold_q <= count;
            flags_q.inp <= (flags_q.inp && !clr.inp) || in_evt;
            flags_q.ovf <= (flags_q.ovf && !clr.ovf) || wrap;
        end
    end

    assign hold     = hold_q;
    assign in_flag  = flags_q.inp;
    assign ovf_flag = flags_q.ovf;
    assign in_irq   = flags_q.inp && ctrl_q.in_ie;
    assign ovf_irq  = flags_q.ovf && ctrl_q.ovf_ie;

    AST_HOLD_COPY: assert property (@(posedge clk) disable iff (rst)
        latch_stb |=> (hold == $past(count))); // R10

    AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.en && !(|lane_wr)) |=> $stable(count)); // R11

    AST_NO_FLAG_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.en && !in_flag) |=> !in_flag); // R11

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (clr.inp && !in_evt) |=> !in_flag); // R8

    AST_GATE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.en && ctrl_q.gated && !tick && !(|lane_wr)) |=> $stable(count)); // R3
endmodule

// File: tb/pacc_top_bench.sv
`timescale 1ns/1ps
module pacc_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin = 1'b0;
    logic        latch_stb = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] count, hold;
    logic        in_flag, ovf_flag, in_irq, ovf_irq;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    string focus  = "R1";

    // reference model state
    logic [6:0]  m_ctrl;
    logic [15:0] m_cnt, m_hold;
    logic        m_inf, m_ovf, m_pin;
    logic [5:0]  m_pre;

    always #2 clk = ~clk;

    pacc_top u_pacc_top (
        .clk (clk), .rst (rst), .pin (pin), .latch_stb (latch_stb),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .count (count), .hold (hold), .in_flag (in_flag), .ovf_flag (ovf_flag),
        .in_irq (in_irq), .ovf_irq (ovf_irq)
    );

    function automatic logic [16:0] next_cnt(logic [15:0] c, logic casc, logic sat);
        if (casc) begin
            if (c == 16'hFFFF) return sat ? {1'b0, c} : {1'b1, 16'h0000};
            return {1'b0, c + 16'd1};
        end
        if (c[7:0] == 8'hFF) return sat ? {1'b0, c} : {1'b1, c[15:8], 8'h00};
        return {1'b0, c[15:8], c[7:0] + 8'd1};
    endfunction

    always @(posedge clk) begin
        logic hit, inc, anyw, wrp, en, pol;
        logic [16:0] nx;
        if (rst) begin
            m_ctrl <= '0; m_cnt <= '0; m_hold <= '0;
            m_inf <= 1'b0; m_ovf <= 1'b0; m_pin <= 1'b0; m_pre <= '0;
        end else begin
            en   = m_ctrl[0];
            pol  = m_ctrl[2];
            hit  = en && (pol ? (!m_pin && pin) : (m_pin && !pin));
            anyw = wr_en && (wr_addr >= 2'd2);
            if (m_ctrl[1]) inc = en && (m_pre == 6'd63) && (pin != pol);
            else           inc = hit;
            nx   = next_cnt(m_cnt, m_ctrl[3], m_ctrl[4]);
            wrp  = inc && !anyw && nx[16];
            if (anyw) begin
                if (wr_addr == 2'd2) m_cnt[7:0]  <= wr_data;
                else                 m_cnt[15:8] <= wr_data;
            end else if (inc) m_cnt <= nx[15:0];
            m_inf <= (m_inf && !(wr_en && wr_addr == 2'd1 && wr_data[0])) || hit;
            m_ovf <= (m_ovf && !(wr_en && wr_addr == 2'd1 && wr_data[1])) || wrp;
            if (latch_stb) m_hold <= m_cnt;
            if (wr_en && wr_addr == 2'd0) m_ctrl <= wr_data[6:0];
            m_pin <= pin;
            m_pre <= m_pre + 6'd1;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare();
        chk({focus, " count"},   32'(count),    32'(m_cnt));
        chk({focus, " hold"},    32'(hold),     32'(m_hold));
        chk({focus, " in_flag"}, 32'(in_flag),  32'(m_inf));
        chk({focus, " ovf"},     32'(ovf_flag), 32'(m_ovf));
        chk({focus, " in_irq"},  32'(in_irq),   32'(m_inf && m_ctrl[5]));
        chk({focus, " ovf_irq"}, 32'(ovf_irq),  32'(m_ovf && m_ctrl[6]));
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare();
        wr_en = 1'b0;
        latch_stb = 1'b0;
    endtask

    task automatic put(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
    endtask

    task automatic set_pin(logic v);
        pin = v;
        cyc();
    endtask

    task automatic pulse();
        set_pin(1'b1);
        set_pin(1'b0);
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] c0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cyc();
        // R1 reset state
        chk("R1 count", 32'(count), 0);
        chk("R1 hold", 32'(hold), 0);
        chk("R1 flags", 32'({in_flag, ovf_flag, in_irq, ovf_irq}), 0);

        // R11 disabled block ignores the pin, presets still land
        focus = "R11";
        pulse();
        chk("R11 count frozen", 32'(count), 0);
        chk("R11 no flag", 32'(in_flag), 0);
        put(2'd2, 8'h40);
        chk("R11 preset", 32'(count), 32'h40);
        put(2'd2, 8'h00);

        // R2 event mode, falling edges (R12 control encoding)
        focus = "R2";
        put(2'd0, 8'h01);
        repeat (3) pulse();
        chk("R2 three falls", 32'(count), 3);
        set_pin(1'b1);
        chk("R2 rise ignored", 32'(count), 3);
        set_pin(1'b0);
        chk("R2 fourth fall", 32'(count), 4);
        chk("R4 flag on fall", 32'(in_flag), 1);
        put(2'd1, 8'h01);
        chk("R8 clear input flag", 32'(in_flag), 0);

        // R2 rising edges with polarity 1
        put(2'd0, 8'h05);
        put(2'd2, 8'h00);
        set_pin(1'b1);
        chk("R2 rise counted", 32'(count), 1);
        chk("R4 flag on rise", 32'(in_flag), 1);
        set_pin(1'b0);
        chk("R2 fall ignored", 32'(count), 1);
        put(2'd1, 8'h01);

        // R5 8-bit wrap
        focus = "R5";
        put(2'd0, 8'h01);
        put(2'd2, 8'hFF);
        put(2'd3, 8'h12);
        pulse();
        chk("R5 wrap keeps high byte", 32'(count), 32'h1200);
        chk("R5 overflow flag", 32'(ovf_flag), 1);

        // R8 set beats clear
        focus = "R8";
        put(2'd2, 8'hFF);
        set_pin(1'b1);
        pin = 1'b0; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h02;
        cyc();
        chk("R8 set wins", 32'(ovf_flag), 1);
        put(2'd1, 8'h02);
        chk("R8 clear overflow", 32'(ovf_flag), 0);
        put(2'd1, 8'h01);

        // R6 cascade
        focus = "R6";
        put(2'd0, 8'h09);
        put(2'd2, 8'hFF);
        put(2'd3, 8'h00);
        pulse();
        chk("R6 carry", 32'(count), 32'h0100);
        chk("R6 no ovf on carry", 32'(ovf_flag), 0);
        put(2'd2, 8'hFF);
        put(2'd3, 8'hFF);
        pulse();
        chk("R6 full wrap", 32'(count), 0);
        chk("R6 ovf on full wrap", 32'(ovf_flag), 1);
        put(2'd1, 8'h03);

        // R7 saturate
        focus = "R7";
        put(2'd0, 8'h11);
        put(2'd3, 8'h00);
        put(2'd2, 8'hFF);
        pulse();
        chk("R7 stops at FF", 32'(count), 32'h00FF);
        chk("R7 no ovf", 32'(ovf_flag), 0);
        put(2'd0, 8'h19);
        put(2'd3, 8'hFF);
        pulse();
        chk("R7 stops at FFFF", 32'(count), 32'hFFFF);
        chk("R7 no ovf cascaded", 32'(ovf_flag), 0);

        // R9 interrupt masking
        focus = "R9";
        put(2'd0, 8'h61);
        chk("R9 input irq", 32'(in_irq), 1);
        chk("R9 ovf irq idle", 32'(ovf_irq), 0);
        pulse();
        chk("R9 wrap count", 32'(count), 32'hFF00);
        chk("R9 ovf irq", 32'(ovf_irq), 1);
        put(2'd0, 8'h01);
        chk("R9 masked", 32'({in_irq, ovf_irq}), 0);
        chk("R9 flags kept", 32'({in_flag, ovf_flag}), 3);

        // R10 holding register
        focus = "R10";
        latch_stb = 1'b1;
        cyc();
        chk("R10 latch", 32'(hold), 32'hFF00);
        pulse();
        chk("R10 hold steady", 32'(hold), 32'hFF00);
        set_pin(1'b1);
        pin = 1'b0; latch_stb = 1'b1;
        cyc();
        chk("R10 latch with edge", 32'(hold), 32'hFF01);
        chk("R10 count after edge", 32'(count), 32'hFF02);

        // R3 gated accumulation
        focus = "R3";
        put(2'd1, 8'h03);
        put(2'd0, 8'h03);
        put(2'd2, 8'h00);
        put(2'd3, 8'h00);
        set_pin(1'b1);
        c0 = count;
        repeat (128) cyc();
        chk("R3 two ticks high", 32'(count), 32'(c0 + 16'd2));
        set_pin(1'b0);
        chk("R4 gated falling flag", 32'(in_flag), 1);
        c0 = count;
        repeat (128) cyc();
        chk("R3 inhibited low", 32'(count), 32'(c0));
        put(2'd0, 8'h07);
        c0 = count;
        repeat (128) cyc();
        chk("R3 two ticks low pol1", 32'(count), 32'(c0 + 16'd2));

        // mixed random traffic: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12
        focus = "random R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12";
        for (int n = 0; n < 4000; n++) begin
            int unsigned r;
            r = $urandom_range(0, 99);
            if (r < 40) pin = ~pin;
            latch_stb = ($urandom_range(0, 99) < 3);
            if ($urandom_range(0, 99) < 6) begin
                wr_en   = 1'b1;
                wr_addr = 2'($urandom_range(0, 3));
                wr_data = 8'($urandom);
                if (wr_addr == 2'd0 && $urandom_range(0, 9) != 0) wr_data[0] = 1'b1;
            end
            cyc();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule